// File: doc/BRIEF.md
# Tagged Register File with Result Broadcast

This block is the rename-side register store of a dynamically scheduled core. Each architectural register holds a data value, a valid flag and the tag of the most recent in-flight instruction that will write it. When an instruction is renamed, its two source registers are read. A source that is valid yields its value. A source that is still pending yields the tag of its producer, and the consumer then waits for that tag.

The same cycle may mark the instruction's destination as pending under a freshly allocated tag. Completed results come back on a broadcast port that carries a tag and a value. Every pending register whose stored tag equals the broadcast tag takes the value and becomes valid. A register that a younger instruction has renamed since then no longer matches, so it keeps waiting for its newest producer.

The source reads are combinational and see a broadcast in the same cycle. They always observe the mapping that held before the current cycle's rename.

Top module: `tagged_regfile`

## Requirements
- R1: After reset every register reads as ready with value 0.
- R2: A lookup of a valid register drives ready=1 and the stored value. A lookup of a pending register drives ready=0 and the stored producer tag on the tag output.
- R3: A rename write (ren_en=1) stores ren_tag in register ren_idx and clears its valid flag. The change is visible to lookups from the next cycle on.
- R4: A broadcast (bc_en=1) fills every pending register whose stored tag equals bc_tag with bc_value and sets it valid in the next cycle. This holds even when several registers wait on the same tag.
- R5: A pending register whose tag differs from bc_tag ignores the broadcast. This covers a register renamed again by a younger writer, which then ignores the older writer's result.
- R6: When a rename write and a matching broadcast target the same register in one cycle, the rename wins and the register stays pending under the new tag.
- R7: A lookup of a pending register in the same cycle as a matching broadcast returns ready=1 with bc_value.
- R8: Lookups in the cycle of a rename write return the mapping from before that rename, including when the source index equals ren_idx.
- R9: A valid register ignores a broadcast, even one whose tag equals its stale stored tag. Its value is unchanged and a same-cycle lookup of it is not bypassed.
- R10: The two lookup ports are independent and may address any registers, including the same one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a_idx | input | IDX_W | Register index for lookup port A |
| src_a_ready | output | 1 | Port A operand is available |
| src_a_value | output | DATA_W | Port A operand value (meaningful when ready) |
| src_a_tag | output | TAG_W | Port A producer tag (meaningful when not ready) |
| src_b_idx | input | IDX_W | Register index for lookup port B |
| src_b_ready | output | 1 | Port B operand is available |
| src_b_value | output | DATA_W | Port B operand value (meaningful when ready) |
| src_b_tag | output | TAG_W | Port B producer tag (meaningful when not ready) |
| ren_en | input | 1 | Mark a destination register pending this cycle |
| ren_idx | input | IDX_W | Destination register index |
| ren_tag | input | TAG_W | Tag of the new producer |
| bc_en | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the completing producer |
| bc_value | input | DATA_W | Result value |

## Verification
The main sweep drives every register through a full life cycle: rename, pending lookup, same-cycle bypass and fill. It uses a distinct value per register, so a wrong index or a port mix-up shows up as a wrong value. Double renaming of one register separates tag matching from index matching, because the older broadcast must be refused. A rename and a broadcast to the same register in one cycle expose the priority between them. A shared tag on two registers shows that the fill reaches all matches. A broadcast whose tag equals the stale tag of a valid register shows that the valid flag gates the fill and the bypass.

// File: rtl/trf_pkg.sv
package trf_pkg;

    // Kind of update applied to one register entry in a cycle.
    typedef enum logic [1:0] {
        UPD_HOLD   = 2'd0,
        UPD_RENAME = 2'd1,
        UPD_FILL   = 2'd2
    } upd_e;

endpackage

// File: rtl/trf_entry.sv
module trf_entry #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4,
    localparam int ENT_W = 1 + TAG_W + DATA_W
) (
    input  logic [ENT_W-1:0]  cur_i,
    input  logic              rename_hit_i,
    input  logic [TAG_W-1:0]  ren_tag_i,
    input  logic              bc_en_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_value_i,
    output logic [ENT_W-1:0]  nxt_o
);
    import trf_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } entry_t;

    entry_t cur;
    entry_t nxt;
    upd_e   upd;

    assign cur = entry_t'(cur_i);

    always_comb begin
        upd = UPD_HOLD;
        if (rename_hit_i) begin
            upd = UPD_RENAME;
        end else if (bc_en_i && !cur.valid && (cur.tag == bc_tag_i)) begin
            upd = UPD_FILL;
        end
    end

    always_comb begin
        nxt = cur;
        case (upd)
            UPD_RENAME: begin
                nxt.valid = 1'b0;
                nxt.tag   = ren_tag_i;
            end
            UPD_FILL: begin
                nxt.valid = 1'b1;
                nxt.value = bc_value_i;
            end
            default: begin
                nxt = cur;
            end
        endcase
    end

    assign nxt_o = nxt;

endmodule

// File: rtl/trf_lookup.sv
module trf_lookup #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int ENT_W   = 1 + TAG_W + DATA_W
) (
    input  logic [NUM_REGS-1:0][ENT_W-1:0] ents_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic                           bc_en_i,
    input  logic [TAG_W-1:0]               bc_tag_i,
    input  logic [DATA_W-1:0]              bc_value_i,
    output logic                           ready_o,
    output logic [DATA_W-1:0]              value_o,
    output logic [TAG_W-1:0]               tag_o
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } entry_t;

    entry_t sel;
    logic   bypass;

    always_comb begin
        sel = entry_t'(ents_i[idx_i]);
        bypass = bc_en_i && !sel.valid && (sel.tag == bc_tag_i);
        ready_o = sel.valid || bypass;
        value_o = bypass ? bc_value_i : sel.value;
        tag_o   = sel.tag;
    end

endmodule

// File: rtl/tagged_regfile.sv
module tagged_regfile #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int ENT_W   = 1 + TAG_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  src_a_idx,
    output logic              src_a_ready,
    output logic [DATA_W-1:0] src_a_value,
    output logic [TAG_W-1:0]  src_a_tag,
    input  logic [IDX_W-1:0]  src_b_idx,
    output logic              src_b_ready,
    output logic [DATA_W-1:0] src_b_value,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              ren_en,
    input  logic [IDX_W-1:0]  ren_idx,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bc_en,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_REGS-1:0] ents;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [NUM_REGS-1:0][ENT_W-1:0] ents_flat;
    logic [NUM_REGS-1:0][ENT_W-1:0] nxt_flat;
    logic [NUM_REGS-1:0]            ren_hit;

    assign ents_flat = st_q.ents;

    // Per-register update logic.
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_ent
        assign ren_hit[gi] = ren_en && (ren_idx == IDX_W'(gi));

        trf_entry #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) i_entry (
            .cur_i        (ents_flat[gi]),
            .rename_hit_i (ren_hit[gi]),
            .ren_tag_i    (ren_tag),
            .bc_en_i      (bc_en),
            .bc_tag_i     (bc_tag),
            .bc_value_i   (bc_value),
            .nxt_o        (nxt_flat[gi])
        );
    end

    // Two independent source read ports.
    trf_lookup #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W)
    ) i_look_a (
        .ents_i     (ents_flat),
        .idx_i      (src_a_idx),
        .bc_en_i    (bc_en),
        .bc_tag_i   (bc_tag),
        .bc_value_i (bc_value),
        .ready_o    (src_a_ready),
        .value_o    (src_a_value),
        .tag_o      (src_a_tag)
    );

    trf_lookup #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W)
    ) i_look_b (
        .ents_i     (ents_flat),
        .idx_i      (src_b_idx),
        .bc_en_i    (bc_en),
        .bc_tag_i   (bc_tag),
        .bc_value_i (bc_value),
        .ready_o    (src_b_ready),
        .value_o    (src_b_value),
        .tag_o      (src_b_tag)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            st_d.ents[i] = entry_t'(nxt_flat[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                st_q.ents[i].valid <= 1'b1;
                st_q.ents[i].tag   <= '0;
                st_q.ents[i].value <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tagged_regfile_chk.sv
module tagged_regfile_chk #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int ENT_W   = 1 + TAG_W + DATA_W
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_REGS-1:0][ENT_W-1:0] ents_i,
    input logic [IDX_W-1:0]               src_a_idx,
    input logic                           src_a_ready,
    input logic [DATA_W-1:0]              src_a_value,
    input logic [TAG_W-1:0]               src_a_tag,
    input logic                           ren_en,
    input logic [IDX_W-1:0]               ren_idx,
    input logic [TAG_W-1:0]               ren_tag,
    input logic                           bc_en,
    input logic [TAG_W-1:0]               bc_tag,
    input logic [DATA_W-1:0]              bc_value
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } entry_t;

    entry_t              e [NUM_REGS];
    logic [NUM_REGS-1:0] hit;
    entry_t              sel_a;

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            e[i]   = entry_t'(ents_i[i]);
            hit[i] = ren_en && (ren_idx == IDX_W'(i));
        end
        sel_a = entry_t'(ents_i[src_a_idx]);
    end

    // R2: a pending lookup shows the producer tag held in the register
    a_r2_pending_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_a_ready) |-> (!sel_a.valid && src_a_tag == sel_a.tag));

    // R7: a ready lookup of a pending register must come from a matching broadcast
    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_ready && !sel_a.valid) |-> (bc_en && bc_tag == sel_a.tag && src_a_value == bc_value));

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_chk
        // R3: rename leaves the register pending under the new tag
        a_r3_rename_pends: assert property (@(posedge clk) disable iff (!rst_n)
            hit[gi] |=> (!e[gi].valid && e[gi].tag == $past(ren_tag)));

        // R4: matching broadcast fills a pending register
        a_r4_fill: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_en && !e[gi].valid && e[gi].tag == bc_tag && !hit[gi])
            |=> (e[gi].valid && e[gi].value == $past(bc_value)));

        // R5: non-matching broadcast leaves a pending register waiting
        a_r5_no_stale_fill: assert property (@(posedge clk) disable iff (!rst_n)
            (!e[gi].valid && !(bc_en && e[gi].tag == bc_tag) && !hit[gi])
            |=> (!e[gi].valid && $stable(e[gi].tag)));

        // R6: rename beats a same-cycle matching broadcast
        a_r6_rename_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[gi] && bc_en && !e[gi].valid && e[gi].tag == bc_tag) |=> (!e[gi].valid));

        // R9: valid registers keep their value without a rename
        a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (e[gi].valid && !hit[gi]) |=> (e[gi].valid && $stable(e[gi].value)));
    end

endmodule

bind tagged_regfile tagged_regfile_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .TAG_W    (TAG_W)
) i_tagged_regfile_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ents_i      (ents_flat),
    .src_a_idx   (src_a_idx),
    .src_a_ready (src_a_ready),
    .src_a_value (src_a_value),
    .src_a_tag   (src_a_tag),
    .ren_en      (ren_en),
    .ren_idx     (ren_idx),
    .ren_tag     (ren_tag),
    .bc_en       (bc_en),
    .bc_tag      (bc_tag),
    .bc_value    (bc_value)
);

// File: tb/test_tagged_regfile.sv
module test_tagged_regfile;
    localparam int NR = 8;
    localparam int DW = 16;
    localparam int TW = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] src_a_idx = '0;
    logic          src_a_ready;
    logic [DW-1:0] src_a_value;
    logic [TW-1:0] src_a_tag;
    logic [IW-1:0] src_b_idx = '0;
    logic          src_b_ready;
    logic [DW-1:0] src_b_value;
    logic [TW-1:0] src_b_tag;
    logic          ren_en = 1'b0;
    logic [IW-1:0] ren_idx = '0;
    logic [TW-1:0] ren_tag = '0;
    logic          bc_en = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_value = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tagged_regfile #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW)) i_tagged_regfile (
        .clk(clk), .rst_n(rst_n),
        .src_a_idx(src_a_idx), .src_a_ready(src_a_ready), .src_a_value(src_a_value), .src_a_tag(src_a_tag),
        .src_b_idx(src_b_idx), .src_b_ready(src_b_ready), .src_b_value(src_b_value), .src_b_tag(src_b_tag),
        .ren_en(ren_en), .ren_idx(ren_idx), .ren_tag(ren_tag),
        .bc_en(bc_en), .bc_tag(bc_tag), .bc_value(bc_value)
    );

    function automatic logic [DW-1:0] val_of(input int i);
        return DW'(16'h1000 + i * 16'h0111);
    endfunction

    // Drive one cycle's operations at the falling edge.
    task automatic apply(input logic re, input int ri, input int rt,
                         input logic be, input int bt, input logic [DW-1:0] bv);
        @(negedge clk);
        ren_en = re; ren_idx = IW'(ri); ren_tag = TW'(rt);
        bc_en = be; bc_tag = TW'(bt); bc_value = bv;
    endtask

    task automatic look(input int a, input int b);
        src_a_idx = IW'(a);
        src_b_idx = IW'(b);
        #1;
    endtask

    // exp_v is the value when exp_rdy=1, otherwise the tag.
    task automatic chk(input string req, input bit port_a, input logic exp_rdy, input int exp_v);
        logic          rdy;
        logic [DW-1:0] got;
        rdy = port_a ? src_a_ready : src_b_ready;
        if (rdy) got = port_a ? src_a_value : src_b_value;
        else     got = DW'(port_a ? src_a_tag : src_b_tag);
        n_chk++;
        if (rdy !== exp_rdy || got !== DW'(exp_v)) begin
            n_fail++;
            $display("FAIL %s port %s: ready=%0b data=%h expected ready=%0b data=%h",
                     req, port_a ? "A" : "B", rdy, got, exp_rdy, DW'(exp_v));
        end
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: ready=x data=x expected ready=1 data=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register valid with value 0 after reset
        for (int i = 0; i < NR; i++) begin
            apply(0, 0, 0, 0, 0, '0);
            look(i, NR - 1 - i);
            chk("R1", 1, 1'b1, 0);
            chk("R1", 0, 1'b1, 0);
        end

        // Full life cycle of every register
        for (int i = 0; i < NR; i++) begin
            apply(1, i, i + 1, 0, 0, '0);
            look(i, i);
            chk("R8", 1, 1'b1, 0);
            apply(0, 0, 0, 0, 0, '0);
            look(i, (i + 1) % NR);
            chk("R3", 1, 1'b0, i + 1);
            chk("R2", 1, 1'b0, i + 1);
            apply(0, 0, 0, 1, i + 1, val_of(i));
            look(i, i);
            chk("R7", 1, 1'b1, val_of(i));
            chk("R10", 0, 1'b1, val_of(i));
            apply(0, 0, 0, 0, 0, '0);
            look(i, (i + NR - 1) % NR);
            chk("R4", 1, 1'b1, val_of(i));
            chk("R2", 1, 1'b1, val_of(i));
        end
        for (int i = 0; i < NR; i++) begin
            apply(0, 0, 0, 0, 0, '0);
            look(NR - 1 - i, i);
            chk("R10", 1, 1'b1, val_of(NR - 1 - i));
            chk("R10", 0, 1'b1, val_of(i));
        end

        // R8: source equal to destination sees the old mapping
        apply(1, 2, 9, 0, 0, '0);
        look(2, 2);
        chk("R8", 1, 1'b1, val_of(2));
        chk("R8", 0, 1'b1, val_of(2));
        apply(0, 0, 0, 0, 0, '0);
        look(2, 2);
        chk("R3", 1, 1'b0, 9);
        apply(0, 0, 0, 1, 9, 16'h2222);
        apply(0, 0, 0, 0, 0, '0);
        look(2, 0);
        chk("R4", 1, 1'b1, 16'h2222);

        // R5: younger rename makes the older broadcast stale
        apply(1, 3, 10, 0, 0, '0);
        apply(1, 3, 11, 0, 0, '0);
        apply(0, 0, 0, 1, 10, 16'hBAD0);
        look(3, 3);
        chk("R5", 1, 1'b0, 11);
        apply(0, 0, 0, 0, 0, '0);
        look(3, 3);
        chk("R5", 1, 1'b0, 11);
        apply(0, 0, 0, 1, 11, 16'h3333);
        apply(0, 0, 0, 0, 0, '0);
        look(3, 3);
        chk("R4", 1, 1'b1, 16'h3333);

        // R6: rename and matching broadcast to the same register in one cycle
        apply(1, 4, 12, 0, 0, '0);
        apply(1, 4, 13, 1, 12, 16'h4444);
        look(4, 5);
        chk("R7", 1, 1'b1, 16'h4444);
        apply(0, 0, 0, 0, 0, '0);
        look(4, 4);
        chk("R6", 1, 1'b0, 13);
        apply(0, 0, 0, 1, 13, 16'h4545);
        apply(0, 0, 0, 0, 0, '0);
        look(4, 4);
        chk("R4", 1, 1'b1, 16'h4545);

        // R4: two registers waiting on one tag both fill
        apply(1, 5, 14, 0, 0, '0);
        apply(1, 6, 14, 0, 0, '0);
        apply(0, 0, 0, 0, 0, '0);
        look(5, 6);
        chk("R3", 1, 1'b0, 14);
        chk("R3", 0, 1'b0, 14);
        apply(0, 0, 0, 1, 14, 16'h5656);
        apply(0, 0, 0, 0, 0, '0);
        look(5, 6);
        chk("R4", 1, 1'b1, 16'h5656);
        chk("R4", 0, 1'b1, 16'h5656);

        // R9: valid register 0 holds stale tag 1; a broadcast of tag 1 is ignored
        apply(0, 0, 0, 1, 1, 16'hDEAD);
        look(0, 7);
        chk("R9", 1, 1'b1, val_of(0));
        chk("R9", 0, 1'b1, val_of(7));
        apply(0, 0, 0, 0, 0, '0);
        look(0, 0);
        chk("R9", 1, 1'b1, val_of(0));

        apply(0, 0, 0, 0, 0, '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule